// File: doc/BRIEF.md
# Ticket-Weighted Lottery Bus Arbiter

This block decides which of four bus masters owns a shared bus. Each master holds a ticket count. Masters with more tickets win more often, but a master with few tickets is never shut out for good. Ticket counts normally arrive on an input and may change every cycle. A build parameter can instead fix them at elaboration.

A master under pressure can raise a boost line, which adds a small per-master bonus to its count. On every drawing the arbiter:

- adds up the effective tickets of the requesting masters as running sums in index order;
- reduces a pseudo-random value from a linear feedback shift register modulo the masked total;
- grants the lowest-index master whose running sum is greater than that reduced value.

The winner keeps the bus for a bounded tenure of several cycles without a new drawing. The next drawing happens during the last cycle of a tenure, so ownership passes on with no dead cycle. The bus datapath and how masters compute their tickets lie outside the block.

Top module: `lottery_arbiter`

## Requirements
- R1: While `rst` is high (sampled at a rising edge), `gnt_o` is 0 on the following cycle, and the random register is loaded with 0x01.
- R2: The random register is an 8-bit Galois shifter. On every rising edge outside reset it shifts one place toward bit 0. When the bit shifted out (bit 0) was 1, it is XORed with mask 0xB8. A drawing uses the value the register holds in that cycle.
- R3: The effective ticket count of master i is its 4-bit field `tkt_i[4i+3:4i]`. When `boost_i[i]` is high, a bonus of 2*(i+1) is added, so masters 0 to 3 gain 2, 4, 6 and 8 tickets.
- R4: With two or more requesters and a nonzero masked total, the running sum S_k is the sum of effective tickets of requesting masters with index up to k. The draw is the random value mod S_3, and the grant goes to the lowest k with draw < S_k. Example: tickets 1,2,3,4 with masters 0, 1 and 3 requesting give sums 1,3,3,7; draw 0 grants master 0 and draw 5 grants master 3.
- R5: When exactly one master requests at a drawing, that master is granted whatever its ticket count, even zero.
- R6: A requesting master with zero effective tickets never wins while another requester has tickets. If all of two or more requesters have zero tickets, the lowest-index requester is granted.
- R7: `gnt_o` is one-hot or zero, and it only ever names a master whose request was high in the previous cycle.
- R8: A drawing happens at an edge when no master owns the bus, when the owner's request is low, or when the owner has held the bus for 4 cycles. At any other edge the grant is held. The owner may win the next drawing again.
- R9: If any request is high at a drawing edge, `gnt_o` is nonzero in the next cycle, so an expiring tenure hands over with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Bus request, one bit per master |
| tkt_i | input | 16 | Ticket counts, 4 bits per master, master i at bits 4i+3:4i |
| boost_i | input | 4 | Per-master bonus request adding extra tickets |
| gnt_o | output | 4 | Registered one-hot grant |

## Verification
The interesting overlap is a tenure reaching its fourth cycle on the same edge that the owner either keeps or drops its request. The drawing for the next owner then coincides with the release of the current one. The bench provokes this by holding several requests for long stretches, so tenures expire back to back with the owner still contending. It also withdraws the owner's request mid-tenure. A cycle-accurate reference of the random register, the tenure counter and the pick rule judges every cycle. Direct checks confirm that a handover leaves no zero-grant cycle, and that a withdrawn owner is replaced on the very next cycle.

// File: rtl/lottery_pkg.sv
package lottery_pkg;

  // Bonus tickets granted to master idx when its boost line is high.
  function automatic int unsigned boost_tickets(input int unsigned idx,
                                                input int unsigned step);
    return (idx + 1) * step;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lottery_lfsr.sv
module lottery_lfsr #(
  parameter int unsigned W    = 8,
  parameter int unsigned TAPS = 32'hB8,
  parameter int unsigned SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] rnd_o
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= W'(SEED);
    end else begin
      state_q <= (state_q >> 1) ^ (state_q[0] ? W'(TAPS) : '0);
    end
  end

  assign rnd_o = state_q;

  // A maximal-length shifter seeded nonzero never reaches the all-zero lock-up state.
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst) state_q != '0); // R2

endmodule

// File: rtl/lottery_tally.sv
module lottery_tally
  import lottery_pkg::*;
#(
  parameter int unsigned           N          = 4,
  parameter int unsigned           TKT_W      = 4,
  parameter int unsigned           EFF_W      = 5,
  parameter int unsigned           SUM_W      = 7,
  parameter int unsigned           BOOST_STEP = 2,
  parameter bit                    DYN_TKT    = 1'b1,
  parameter logic [N*TKT_W-1:0]    STATIC_TKT = '0
) (
  input  logic [N-1:0]       req_i,
  input  logic [N*TKT_W-1:0] tkt_i,
  input  logic [N-1:0]       boost_i,
  output logic [N*SUM_W-1:0] sums_o
);

  logic [SUM_W-1:0] masked [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_mst
    localparam int unsigned BONUS = boost_tickets(gi, BOOST_STEP);
    logic [TKT_W-1:0] base;
    logic [EFF_W-1:0] eff;

    if (DYN_TKT) begin : g_dyn
      assign base = tkt_i[gi*TKT_W +: TKT_W];
    end else begin : g_fix
      assign base = STATIC_TKT[gi*TKT_W +: TKT_W];
    end

    assign eff        = EFF_W'(base) + (boost_i[gi] ? EFF_W'(BONUS) : '0);
    assign masked[gi] = req_i[gi] ? SUM_W'(eff) : '0;
  end

  // Running sums in index order; the last one is the masked total.
  always_comb begin
    logic [SUM_W-1:0] acc;
    acc    = '0;
    sums_o = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + masked[i];
      sums_o[i*SUM_W +: SUM_W] = acc;
    end
  end

endmodule

// File: rtl/lottery_pick.sv
module lottery_pick
  import lottery_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned SUM_W = 7,
  parameter int unsigned RND_W = 8
) (
  input  logic [N-1:0]       req_i,
  input  logic [N*SUM_W-1:0] sums_i,
  input  logic [RND_W-1:0]   rnd_i,
  output logic [N-1:0]       pick_o
);

  localparam int unsigned MW = max_u(SUM_W, RND_W);

  logic [MW-1:0] total;
  logic [MW-1:0] draw;
  logic          hit;
  logic          sole;

  assign total = MW'(sums_i[(N-1)*SUM_W +: SUM_W]);
  assign sole  = ($countones(req_i) == 1);

  always_comb begin
    pick_o = '0;
    draw   = '0;
    hit    = 1'b0;
    if (sole) begin
      pick_o = req_i;
    end else if (total == '0) begin
      // Only zero-ticket requesters (or none): fall back to lowest index.
      for (int i = 0; i < N; i++) begin
        if (!hit && req_i[i]) begin
          pick_o[i] = 1'b1;
          hit       = 1'b1;
        end
      end
    end else begin
      draw = MW'(rnd_i) % total;
      for (int i = 0; i < N; i++) begin
        if (!hit && (draw < MW'(sums_i[i*SUM_W +: SUM_W]))) begin
          pick_o[i] = 1'b1;
          hit       = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lottery_arbiter.sv
module lottery_arbiter
  import lottery_pkg::*;
#(
  parameter int unsigned              N_MST      = 4,
  parameter int unsigned              TKT_W      = 4,
  parameter int unsigned              MAX_XFER   = 4,
  parameter int unsigned              LFSR_W     = 8,
  parameter int unsigned              LFSR_TAPS  = 32'hB8,
  parameter int unsigned              LFSR_SEED  = 1,
  parameter int unsigned              BOOST_STEP = 2,
  parameter bit                       DYN_TKT    = 1'b1,
  parameter logic [N_MST*TKT_W-1:0]   STATIC_TKT = 16'h4321
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_MST-1:0]         req_i,
  input  logic [N_MST*TKT_W-1:0]   tkt_i,
  input  logic [N_MST-1:0]         boost_i,
  output logic [N_MST-1:0]         gnt_o
);

  localparam int unsigned MAX_EFF = (2**TKT_W - 1) + N_MST * BOOST_STEP;
  localparam int unsigned EFF_W   = $clog2(MAX_EFF + 1);
  localparam int unsigned SUM_W   = $clog2(N_MST * MAX_EFF + 1);
  localparam int unsigned CNT_W   = $clog2(MAX_XFER + 1);

  logic [LFSR_W-1:0]      rnd;
  logic [N_MST*SUM_W-1:0] sums;
  logic [N_MST-1:0]       pick;
  logic [N_MST-1:0]       gnt_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   tenure_end;
  logic                   redraw;

  lottery_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .rnd_o (rnd)
  );

  lottery_tally #(
    .N          (N_MST),
    .TKT_W      (TKT_W),
    .EFF_W      (EFF_W),
    .SUM_W      (SUM_W),
    .BOOST_STEP (BOOST_STEP),
    .DYN_TKT    (DYN_TKT),
    .STATIC_TKT (STATIC_TKT)
  ) u_tally (
    .req_i   (req_i),
    .tkt_i   (tkt_i),
    .boost_i (boost_i),
    .sums_o  (sums)
  );

  lottery_pick #(
    .N     (N_MST),
    .SUM_W (SUM_W),
    .RND_W (LFSR_W)
  ) u_pick (
    .req_i  (req_i),
    .sums_i (sums),
    .rnd_i  (rnd),
    .pick_o (pick)
  );

  // The drawing for the next owner is taken in the last cycle of the current tenure.
  assign tenure_end = (cnt_q == CNT_W'(MAX_XFER - 1));
  assign redraw     = ((gnt_q & req_i) == '0) || tenure_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
      cnt_q <= '0;
    end else if (redraw) begin
      gnt_q <= pick;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R7

  AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != '0) |-> ((gnt_q & $past(req_i)) != '0)); // R7

  AST_SOLE_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(redraw) && ($countones($past(req_i)) == 1))
      |-> (gnt_q == $past(req_i))); // R5

  AST_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(redraw) && ($past(req_i) != '0)) |-> (gnt_q != '0)); // R9

  AST_TENURE_CAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(MAX_XFER - 1)) |=> (cnt_q == '0)); // R8

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(redraw)) |-> $stable(gnt_q)); // R8

endmodule

// File: tb/lottery_arbiter_tb_top.sv
`timescale 1ns/1ps
module lottery_arbiter_tb_top;

  localparam int MAXX = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req = '0;
  logic [15:0] tkt = '0;
  logic [3:0]  boost = '0;
  logic [3:0]  gnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lottery_arbiter dut_i (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .tkt_i   (tkt),
    .boost_i (boost),
    .gnt_o   (gnt)
  );

  // Reference model built from the requirements.
  logic [7:0] m_lfsr;
  logic [3:0] m_gnt;
  int         m_cnt;
  bit         m_redraw;
  int         m_draw;
  logic [3:0] p_nxt;
  int         d_nxt;
  bit         rd_nxt;

  function automatic logic [3:0] ref_pick(input logic [3:0] r, input logic [15:0] t,
                                          input logic [3:0] b, input logic [7:0] rnd,
                                          output int draw);
    int sum [4];
    int acc;
    int first;
    int nreq;
    logic [3:0] res;
    acc = 0; first = -1; nreq = 0; res = '0; draw = -1;
    for (int i = 0; i < 4; i++) begin
      int eff;
      eff = int'(t[4*i +: 4]) + (b[i] ? 2 * (i + 1) : 0);
      if (r[i]) begin
        acc += eff;
        nreq++;
        if (first < 0) first = i;
      end
      sum[i] = acc;
    end
    if (nreq == 1) res[first] = 1'b1;
    else if (nreq > 1 && acc == 0) res[first] = 1'b1;
    else if (nreq > 1) begin
      draw = int'(rnd) % acc;
      for (int i = 0; i < 4; i++) begin
        if (draw < sum[i]) begin
          res[i] = 1'b1;
          break;
        end
      end
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lfsr   <= 8'h01;
      m_gnt    <= '0;
      m_cnt    <= 0;
      m_redraw <= 1'b0;
      m_draw   <= -1;
    end else begin
      rd_nxt = ((m_gnt & req) == '0) || (m_cnt == MAXX - 1);
      p_nxt  = ref_pick(req, tkt, boost, m_lfsr, d_nxt);
      if (rd_nxt) begin
        m_gnt <= p_nxt;
        m_cnt <= 0;
      end else begin
        m_cnt <= m_cnt + 1;
      end
      m_redraw <= rd_nxt;
      m_draw   <= rd_nxt ? d_nxt : -1;
      m_lfsr   <= {1'b0, m_lfsr[7:1]} ^ (m_lfsr[0] ? 8'hB8 : 8'h00);
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run_cmp(input string tag, input int n);
    repeat (n) begin
      @(negedge clk);
      chk(tag, gnt, m_gnt);
    end
  endtask

  task automatic flush();
    req = '0; boost = '0;
    repeat (2) @(negedge clk);
    chk("R7 no request gives no grant", gnt, 4'b0000);
  endtask

  task automatic t_reset();
    rst = 1'b1; req = 4'hF; tkt = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 grant cleared in reset", gnt, 4'b0000);
    rst = 1'b0;
    run_cmp("R2 random sequence from seed", 24);
  endtask

  task automatic t_example();
    int seen0;
    int seen5;
    seen0 = 0; seen5 = 0;
    flush();
    req = 4'b1011; tkt = 16'h4321;
    for (int c = 0; c < 240; c++) begin
      @(negedge clk);
      chk("R4 ticket lottery", gnt, m_gnt);
      if (m_redraw && m_draw == 0) begin
        seen0++;
        chk("R4 draw 0 picks master 0", gnt, 4'b0001);
      end
      if (m_redraw && m_draw == 5) begin
        seen5++;
        chk("R4 draw 5 picks master 3", gnt, 4'b1000);
      end
    end
    if (seen0 == 0 || seen5 == 0) $display("note: example draws 0/5 seen %0d/%0d", seen0, seen5);
  endtask

  task automatic t_boost();
    flush();
    req = 4'b1111; tkt = 16'h1111; boost = 4'b0100;
    run_cmp("R3 boosted lottery", 60);
    flush();
    req = 4'b1001; tkt = 16'h0000; boost = 4'b1000;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R3 boost gives master 3 eight tickets", gnt, 4'b1000);
    end
  endtask

  task automatic t_single();
    flush();
    req = 4'b0010; tkt = 16'h0000;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R5 sole zero-ticket requester granted", gnt, 4'b0010);
    end
    chk("R9 sole owner kept across tenures", gnt, m_gnt);
  endtask

  task automatic t_zero();
    flush();
    req = 4'b1111; tkt = 16'h0500;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      chk("R6 zero-ticket masters never win", gnt, 4'b0100);
    end
    flush();
    req = 4'b0110; tkt = 16'h0000;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk("R6 all zero picks lowest requester", gnt, 4'b0010);
    end
  endtask

  task automatic t_tenure();
    logic [3:0] owner;
    flush();
    req = 4'b0011; tkt = 16'h0033;
    run_cmp("R8 tenure and redraw", 30);
    owner = gnt;
    req = 4'b0011 & ~owner;
    @(negedge clk);
    chk("R8 withdrawn owner replaced next cycle", gnt, 4'b0011 & ~owner);
    req = 4'b0011;
    run_cmp("R8 tenure after release", 20);
  endtask

  task automatic t_noidle();
    flush();
    req = 4'b1111; tkt = 16'h9C37; boost = 4'b0011;
    @(negedge clk);
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      chk("R7 grant matches lottery", gnt, m_gnt);
      chk("R9 no idle cycle at handover", {3'b000, gnt != 4'b0000}, 4'b0001);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_boost();
    t_single();
    t_zero();
    t_tenure();
    t_noidle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule